// File: doc/BRIEF.md
# Cascadable TFT Gate Scan Sequencer

This block is the logic core of a row (gate) driver for an active-matrix LCD panel. It has a parameterised number of row outputs, 300 by default. An active-low start pulse is sampled on the vertical shift clock. Once the pulse has been captured, the block drives its rows active one at a time, in the order set by a direction input. The outputs are plain logic levels. Level shifting to panel voltages happens outside the block.

Up to four identical chips can share one clock and one start pulse with no wire running from one chip to the next. Each chip counts clocks from the captured start pulse. It decodes its place in the chain from two strap inputs together with the direction input, and it drives its rows only while the count lies inside its own window. A two-bit mode input selects single-pulse scanning, continuous double-pulse scanning, jumping double-pulse scanning, or every output held inactive. The last setting is used to flush the block after power-up.

Top module: `gscan_top`

## Requirements
- R1: After reset, and until a start pulse has been captured, every bit of `rowOut` is 0 whatever the mode.
- R2: `startN` is active low and is sampled on each rising `clk` edge. Call the last edge that sees it low edge 0. Scan index s of the chip at position k (zero-based) is first asserted on `rowOut` after edge k*NUM_ROWS + s + 1.
- R3: With `dirFwd`=1, scan index s maps to `rowOut[s]`. With `dirFwd`=0, it maps to `rowOut[NUM_ROWS-1-s]`.
- R4: Chain position comes from `strap`={a,b}. With `dirFwd`=1: {1,1} is 1st, {0,1} is 2nd, {1,0} is 3rd and {0,0} is 4th. With `dirFwd`=0 the order is reversed: {1,1} is 4th, {0,1} is 3rd, {1,0} is 2nd and {0,0} is 1st.
- R5: `modeSel`=2'b11 (single pulse): each row is active for exactly one clock period, and at most one row is active at a time.
- R6: `modeSel`=2'b01 (continuous double pulse): each row is active for two consecutive clock periods, so neighbouring rows overlap by one period.
- R7: `modeSel`=2'b10 (jumping double pulse): each row is active in two one-period pulses with exactly JUMP_GAP idle periods between them. The second pulse starts JUMP_GAP+1 clocks after the first.
- R8: `modeSel`=2'b00: every bit of `rowOut` is 0 after the next clock edge.
- R9: A start pulse captured in the middle of a frame clears every row on that edge and restarts the scan from the beginning.
- R10: Once the chip's window, including any second-pulse tail, has passed, all rows stay 0 until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Vertical shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startN | input | 1 | Active-low frame start pulse |
| dirFwd | input | 1 | Scan direction; 1 scans from bit 0 upward |
| modeSel | input | 2 | Pulse scheme select (see R5 to R8) |
| strap | input | 2 | Chain position straps {a,b} |
| rowOut | output | NUM_ROWS | Row select outputs; 1 means the row is selected |

## Verification
The bench sweeps every combination of direction, strap setting and mode on a six-row configuration. It compares each output cycle against a schedule worked out from the chain position arithmetic. A design that swapped the strap table for one direction would light its rows in another chip's window. A design that mirrored the wrong way would start at the far end. The sweep also runs well past the last chip's window. This exposes a counter that wraps and scans a second time, and a jumping-mode tail that is cut off at the window edge. A restart in the middle of a frame checks that old rows are dropped on the capturing edge rather than one clock later.

// File: rtl/gscan_pkg.sv
package gscan_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_CONT   = 2'b01,
    MODE_JUMP   = 2'b10,
    MODE_SINGLE = 2'b11
  } scan_mode_e;

  // Strobes from control to the row datapath
  typedef struct packed {
    logic       clearRows;
    logic       scanEn;
    logic       dirFwd;
    scan_mode_e mode;
  } scan_ctl_t;

  localparam int unsigned CHAIN_MAX = 4;

endpackage

// File: rtl/gscan_ctrl.sv
module gscan_ctrl
  import gscan_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 300,
  parameter int unsigned JUMP_GAP = 2,
  parameter int unsigned TW       = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          startN,
  input  logic          dirFwd,
  input  logic [1:0]    modeSel,
  input  logic [1:0]    strap,
  output scan_ctl_t     ctl,
  output logic [TW-1:0] tick,
  output logic [TW-1:0] base
);

  // last count value; lies beyond every chip's window and tail
  localparam logic [TW-1:0] TICK_LAST = TW'(CHAIN_MAX * NUM_ROWS + JUMP_GAP + 1);

  logic       running;
  logic [1:0] posFwd;
  logic [1:0] chainPos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      tick    <= '0;
    end else if (!startN) begin
      running <= 1'b1;
      tick    <= '0;
    end else if (running && (tick != TICK_LAST)) begin
      tick <= tick + TW'(1);
    end
  end

  // forward order: {1,1}->0, {0,1}->1, {1,0}->2, {0,0}->3
  always_comb begin
    posFwd   = {~strap[0], ~strap[1]};
    chainPos = dirFwd ? posFwd : (2'd3 - posFwd);
    base     = TW'(chainPos) * TW'(NUM_ROWS);
  end

  always_comb begin
    ctl.clearRows = ~startN;
    ctl.scanEn    = running;
    ctl.dirFwd    = dirFwd;
    ctl.mode      = scan_mode_e'(modeSel);
  end

endmodule

// File: rtl/gscan_rows.sv
module gscan_rows
  import gscan_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 300,
  parameter int unsigned JUMP_GAP = 2,
  parameter int unsigned TW       = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  scan_ctl_t           ctl,
  input  logic [TW-1:0]       tick,
  input  logic [TW-1:0]       base,
  output logic [NUM_ROWS-1:0] rowOut
);

  localparam logic [TW-1:0] SECOND_OFS = TW'(JUMP_GAP + 1);

  logic                inWin;
  logic [TW-1:0]       idx;
  logic                firstOn;
  logic                contOn;
  logic                jumpOn;
  logic [NUM_ROWS-1:0] hit;

  always_comb begin
    inWin   = ctl.scanEn && (tick >= base);
    idx     = tick - base;
    firstOn = inWin && (ctl.mode != MODE_OFF);
    contOn  = inWin && (ctl.mode == MODE_CONT);
    jumpOn  = inWin && (ctl.mode == MODE_JUMP);
  end

  for (genvar p = 0; p < NUM_ROWS; p++) begin : g_row
    localparam logic [TW-1:0] IDX_FWD = TW'(p);
    localparam logic [TW-1:0] IDX_REV = TW'(NUM_ROWS - 1 - p);
    logic [TW-1:0] slot;
    assign slot   = ctl.dirFwd ? IDX_FWD : IDX_REV;
    assign hit[p] = (firstOn && (idx == slot))
                  | (contOn  && (idx == slot + TW'(1)))
                  | (jumpOn  && (idx == slot + SECOND_OFS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rowOut <= '0;
    else if (ctl.clearRows) rowOut <= '0;
    else                    rowOut <= hit;
  end

endmodule

// File: rtl/gscan_top.sv
module gscan_top
  import gscan_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 300,
  parameter int unsigned JUMP_GAP = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                startN,
  input  logic                dirFwd,
  input  logic [1:0]          modeSel,
  input  logic [1:0]          strap,
  output logic [NUM_ROWS-1:0] rowOut
);

  localparam int unsigned TW = $clog2(CHAIN_MAX * NUM_ROWS + JUMP_GAP + 2);

  scan_ctl_t     ctl;
  logic [TW-1:0] tick;
  logic [TW-1:0] base;

  gscan_ctrl #(.NUM_ROWS(NUM_ROWS), .JUMP_GAP(JUMP_GAP), .TW(TW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startN(startN), .dirFwd(dirFwd),
    .modeSel(modeSel), .strap(strap), .ctl(ctl), .tick(tick), .base(base)
  );

  gscan_rows #(.NUM_ROWS(NUM_ROWS), .JUMP_GAP(JUMP_GAP), .TW(TW)) u_rows (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .tick(tick), .base(base),
    .rowOut(rowOut)
  );

endmodule

// File: rtl/gscan_chk.sv
module gscan_chk #(
  parameter int unsigned NUM_ROWS = 300
) (
  input logic                clk,
  input logic                rst_n,
  input logic                startN,
  input logic [1:0]          modeSel,
  input logic [NUM_ROWS-1:0] rowOut
);

  // R8
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == 2'b00) |=> (rowOut == '0));

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!startN) |=> (rowOut == '0));

  // R5
  single_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == 2'b11) |=> $onehot0(rowOut));

  // R5
  single_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == 2'b11 && startN && (rowOut != '0)) |=> ((rowOut & $past(rowOut)) == '0));

  // R6
  cont_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == 2'b01) |=> ($countones(rowOut) <= 2));

  // R7
  jump_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == 2'b10) |=> ($countones(rowOut) <= 2));

endmodule

bind gscan_top gscan_chk #(.NUM_ROWS(NUM_ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .startN(startN), .modeSel(modeSel), .rowOut(rowOut)
);

// File: tb/tb_gscan_top.sv
module tb_gscan_top;

  localparam int N     = 6;
  localparam int GAP   = 2;
  localparam int TLAST = 4 * N + GAP + 1;
  localparam int FRAME = TLAST + 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         startN = 1'b1;
  logic         dirFwd = 1'b1;
  logic [1:0]   modeSel = 2'b00;
  logic [1:0]   strap = 2'b11;
  logic [N-1:0] rowOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit doneFlag = 1'b0;

  always #10 clk = ~clk;

  gscan_top #(.NUM_ROWS(N), .JUMP_GAP(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .startN(startN), .dirFwd(dirFwd),
    .modeSel(modeSel), .strap(strap), .rowOut(rowOut)
  );

  // position from the strap table (R4)
  function automatic int chainPos(bit dir, bit [1:0] st);
    int f;
    case (st)
      2'b11: f = 0;
      2'b01: f = 1;
      2'b10: f = 2;
      default: f = 3;
    endcase
    return dir ? f : 3 - f;
  endfunction

  // expected rows m edges after the capturing edge
  function automatic logic [N-1:0] expRows(int m, bit dir, bit [1:0] st, bit [1:0] md);
    logic [N-1:0] r;
    int t, i, b, j;
    r = '0;
    if (m < 1) return r;
    t = m - 1;
    if (t > TLAST) t = TLAST;
    b = chainPos(dir, st) * N;
    if (t < b) return r;
    i = t - b;
    for (int p = 0; p < N; p++) begin
      j = dir ? p : N - 1 - p;
      case (md)
        2'b11: r[p] = (i == j);
        2'b01: r[p] = (i == j) || (i == j + 1);
        2'b10: r[p] = (i == j) || (i == j + GAP + 1);
        default: r[p] = 1'b0;
      endcase
    end
    return r;
  endfunction

  task automatic check(logic [N-1:0] got, logic [N-1:0] exp, string tag);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!doneFlag) begin
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    // R1: reset state and no scanning without a start pulse
    check(rowOut, '0, "R1 reset");
    rst_n = 1'b1;
    modeSel = 2'b11;
    for (int c = 0; c < 10; c++) begin
      @(posedge clk); @(negedge clk);
      check(rowOut, '0, "R1 idle before start");
    end

    // exhaustive sweep: R2 R3 R4 with R5 R6 R7 R8, tail for R10
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 4; s++) begin
        for (int md = 0; md < 4; md++) begin
          dirFwd  = d[0];
          strap   = s[1:0];
          modeSel = md[1:0];
          startN  = 1'b0;
          @(posedge clk); @(negedge clk);
          startN = 1'b1;
          case (md)
            3: tag = "R5";
            1: tag = "R6";
            2: tag = "R7";
            default: tag = "R8";
          endcase
          check(rowOut, '0, $sformatf("R9 capture edge d=%0d s=%0d md=%0d", d, s, md));
          for (int m = 1; m <= FRAME; m++) begin
            @(posedge clk); @(negedge clk);
            check(rowOut, expRows(m, d[0], s[1:0], md[1:0]),
                  $sformatf("%s R2 R3 R4 R10 d=%0d s=%0d md=%0d m=%0d", tag, d, s, md, m));
          end
        end
      end
    end

    // R10: long idle after frame end stays quiet
    for (int c = 0; c < 10; c++) begin
      @(posedge clk); @(negedge clk);
      check(rowOut, '0, "R10 post-frame idle");
    end

    // R9: restart mid-frame, single-pulse, first position
    dirFwd = 1'b1; strap = 2'b11; modeSel = 2'b11;
    startN = 1'b0;
    @(posedge clk); @(negedge clk);
    startN = 1'b1;
    for (int m = 1; m <= 3; m++) begin
      @(posedge clk); @(negedge clk);
    end
    check(rowOut, 6'b000100, "R9 before restart");
    startN = 1'b0;
    @(posedge clk); @(negedge clk);
    startN = 1'b1;
    check(rowOut, '0, "R9 rows cleared on restart edge");
    for (int m = 1; m <= 8; m++) begin
      @(posedge clk); @(negedge clk);
      check(rowOut, expRows(m, 1'b1, 2'b11, 2'b11), $sformatf("R9 rescan m=%0d", m));
    end

    doneFlag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule